// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block is a byte-wide configuration register bank for a two-channel converter. It sits behind a simple parallel register bus with address, write data, a write strobe, a read strobe and read data. Some registers are global: they exist once and act on the whole device. The others are local: each exists in four physical copies, one per data channel (A and B) and one per clock-output channel (the data clock and the frame clock).

A device index register chooses the copies that a local write reaches. A single write is broadcast to every selected copy in the same cycle. The index register also chooses the one copy that a local read returns. Global registers never look at the index.

A self-clearing soft-reset bit in the chip configuration register starts a two-state sequencer, with states ST_RUN and ST_RELOAD. The sequencer has two transitions:
- ST_RUN to ST_RELOAD, taken on a write of address 0x00 with bit 5 set.
- ST_RELOAD to ST_RUN, taken unconditionally one cycle later.

In the ST_RELOAD cycle every register, local copies included, loads its default value, and bus writes are dropped.

Top module: `crb_bank`

## Requirements
- R1: After the reset input is released, reads return the following values: 0x00 at address 0x00, CHIP_ID (0x8B) at 0x01, CHIP_GRADE (0x20) at 0x02, 0x33 at 0x05, 0x00 at 0x08 and 0x04 at 0x18. Every local copy reads 0x00 at 0x0D and 0x01 at 0x14.
- R2: The index register at 0x05 has the following bit map: bit 0 selects channel A, bit 1 selects channel B, bit 5 selects the data-clock copy and bit 4 selects the frame-clock copy. Bits [7:6] and [3:2] always read as zero, whatever is written.
- R3: A write to a local address (0x0D or 0x14) updates, in the same clock edge, every copy whose select bit is set. Copies that are not selected keep their value. With no select bit set, no copy changes.
- R4: A local read returns one copy, chosen by priority: channel A if bit 0 is set, otherwise B if bit 1 is set, otherwise the data-clock copy if bit 5 is set, otherwise the frame-clock copy if bit 4 is set. With no select bit set, the read returns 0x00.
- R5: The global registers at 0x08 and 0x18 are written and read the same way whatever the index register holds, including an index of 0x00.
- R6: Writing 0x00 with bit 5 set causes all registers to reload their R1 defaults at the following clock edge. A bus write presented at that following edge is dropped. Bit 5 of 0x00 always reads as zero.
- R7: A write to an unsupported address, or to the read-only addresses 0x01 and 0x02, changes nothing. A read from an unsupported address returns 0x00.
- R8: rd_valid is high for exactly the cycle after each cycle in which rd_en is sampled high. rdata carries the register contents as they stood at that edge. rd_valid is low after any cycle without rd_en.
- R9: Only the implemented field bits are stored, and all other bits read as zero. The implemented fields are: 0x00 bits [1:0], 0x08 bits [1:0], 0x18 bits [2:0], 0x0D bits [3:0] and 0x14 bits [2:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The assertions assume that wr_en and rd_en are single-cycle strobes, that addr and wdata are stable while a strobe is high, and that reset is applied once before any bus traffic. The stimulus meets these assumptions by driving every bus field on the falling clock edge and returning each strobe low one cycle later. The only case where a strobe is held for two cycles is the soft-reset test, which does so on purpose to present a write during ST_RELOAD. Reads are never issued during the reload cycle, so every read-data check sees settled register state.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int BYTE_W = 8;
    localparam int NCOPY  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // copy slots
    localparam int CP_A   = 0;
    localparam int CP_B   = 1;
    localparam int CP_DCK = 2;
    localparam int CP_FCK = 3;

    // address map
    localparam byte_t A_CFG   = 8'h00;
    localparam byte_t A_ID    = 8'h01;
    localparam byte_t A_GRADE = 8'h02;
    localparam byte_t A_INDEX = 8'h05;
    localparam byte_t A_PWR   = 8'h08;
    localparam byte_t A_TEST  = 8'h0D;
    localparam byte_t A_OUT   = 8'h14;
    localparam byte_t A_REF   = 8'h18;

    // field masks
    localparam byte_t M_CFG   = 8'h03;
    localparam byte_t M_INDEX = 8'h33;
    localparam byte_t M_PWR   = 8'h03;
    localparam byte_t M_TEST  = 8'h0F;
    localparam byte_t M_OUT   = 8'h07;
    localparam byte_t M_REF   = 8'h07;

    // defaults
    localparam byte_t D_CFG   = 8'h00;
    localparam byte_t D_INDEX = 8'h33;
    localparam byte_t D_PWR   = 8'h00;
    localparam byte_t D_TEST  = 8'h00;
    localparam byte_t D_OUT   = 8'h01;
    localparam byte_t D_REF   = 8'h04;

    localparam int SRST_BIT = 5;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_RELOAD = 1'b1
    } srst_state_e;

    // index bit that selects a given copy
    function automatic int sel_bit(input int cp);
        case (cp)
            CP_A:    return 0;
            CP_B:    return 1;
            CP_DCK:  return 5;
            default: return 4;
        endcase
    endfunction

    function automatic logic is_mapped(input byte_t a);
        return (a == A_CFG) || (a == A_ID) || (a == A_GRADE) ||
               (a == A_INDEX) || (a == A_PWR) || (a == A_TEST) ||
               (a == A_OUT) || (a == A_REF);
    endfunction

endpackage

// File: rtl/crb_srst_fsm.sv
module crb_srst_fsm
    import crb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    output logic reload,
    output logic bus_open
);

    srst_state_e state_q;
    srst_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        reload   = 1'b0;
        bus_open = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                bus_open = 1'b1;
                if (srst_req) begin
                    state_d = ST_RELOAD;
                end
            end
            ST_RELOAD: begin
                reload  = 1'b1;
                state_d = ST_RUN;
            end
        endcase
    end

    // R6: the reload state lasts a single cycle
    a_r6_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOAD) |=> (state_q == ST_RUN));

    // R6: a soft-reset request is never lost
    a_r6_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> reload);

endmodule

// File: rtl/crb_local_copy.sv
module crb_local_copy
    import crb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  reload,
    input  logic  we_test,
    input  logic  we_out,
    input  byte_t wdata,
    output byte_t test_q,
    output byte_t out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_q <= D_TEST;
            out_q  <= D_OUT;
        end else if (reload) begin
            test_q <= D_TEST;
            out_q  <= D_OUT;
        end else begin
            if (we_test) test_q <= wdata & M_TEST;
            if (we_out)  out_q  <= wdata & M_OUT;
        end
    end

    // R3: an unselected copy holds its contents
    a_r3_copy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !we_test && !we_out) |=> ($stable(test_q) && $stable(out_q)));

    // R6: a reload restores this copy's defaults
    a_r6_copy_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (test_q == D_TEST && out_q == D_OUT));

endmodule

// File: rtl/crb_read_mux.sv
module crb_read_mux
    import crb_pkg::*;
#(
    parameter byte_t CHIP_ID    = 8'h8B,
    parameter byte_t CHIP_GRADE = 8'h20
) (
    input  byte_t                   addr,
    input  byte_t                   cfg_q,
    input  byte_t                   idx_q,
    input  byte_t                   pwr_q,
    input  byte_t                   ref_q,
    input  logic [NCOPY-1:0][BYTE_W-1:0] test_q,
    input  logic [NCOPY-1:0][BYTE_W-1:0] out_q,
    output byte_t                   rd_byte
);

    logic  any_sel;
    byte_t test_pick;
    byte_t out_pick;

    // priority: A, B, data clock, frame clock
    always_comb begin
        any_sel   = 1'b1;
        test_pick = 8'h00;
        out_pick  = 8'h00;
        if (idx_q[sel_bit(CP_A)]) begin
            test_pick = test_q[CP_A];
            out_pick  = out_q[CP_A];
        end else if (idx_q[sel_bit(CP_B)]) begin
            test_pick = test_q[CP_B];
            out_pick  = out_q[CP_B];
        end else if (idx_q[sel_bit(CP_DCK)]) begin
            test_pick = test_q[CP_DCK];
            out_pick  = out_q[CP_DCK];
        end else if (idx_q[sel_bit(CP_FCK)]) begin
            test_pick = test_q[CP_FCK];
            out_pick  = out_q[CP_FCK];
        end else begin
            any_sel = 1'b0;
        end
    end

    always_comb begin
        case (addr)
            A_CFG:   rd_byte = cfg_q;
            A_ID:    rd_byte = CHIP_ID;
            A_GRADE: rd_byte = CHIP_GRADE;
            A_INDEX: rd_byte = idx_q;
            A_PWR:   rd_byte = pwr_q;
            A_REF:   rd_byte = ref_q;
            A_TEST:  rd_byte = any_sel ? test_pick : 8'h00;
            A_OUT:   rd_byte = any_sel ? out_pick  : 8'h00;
            default: rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/crb_bank.sv
module crb_bank
    import crb_pkg::*;
#(
    parameter logic [7:0] CHIP_ID    = 8'h8B,
    parameter logic [7:0] CHIP_GRADE = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rdata,
    output logic       rd_valid
);

    logic  reload;
    logic  bus_open;
    logic  wr_ok;
    logic  srst_req;
    byte_t cfg_q;
    byte_t idx_q;
    byte_t pwr_q;
    byte_t ref_q;
    byte_t rd_byte;
    logic [NCOPY-1:0]             we_test;
    logic [NCOPY-1:0]             we_out;
    logic [NCOPY-1:0][BYTE_W-1:0] test_q;
    logic [NCOPY-1:0][BYTE_W-1:0] out_q;

    assign wr_ok    = wr_en && bus_open;
    assign srst_req = wr_ok && (addr == A_CFG) && wdata[SRST_BIT];

    crb_srst_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_req (srst_req),
        .reload   (reload),
        .bus_open (bus_open)
    );

    // global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= D_CFG;
            idx_q <= D_INDEX;
            pwr_q <= D_PWR;
            ref_q <= D_REF;
        end else if (reload) begin
            cfg_q <= D_CFG;
            idx_q <= D_INDEX;
            pwr_q <= D_PWR;
            ref_q <= D_REF;
        end else if (wr_ok) begin
            case (addr)
                A_CFG:   cfg_q <= wdata & M_CFG;
                A_INDEX: idx_q <= wdata & M_INDEX;
                A_PWR:   pwr_q <= wdata & M_PWR;
                A_REF:   ref_q <= wdata & M_REF;
                default: ;
            endcase
        end
    end

    // local copies, one per selectable channel
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        assign we_test[c] = wr_ok && (addr == A_TEST) && idx_q[sel_bit(c)];
        assign we_out[c]  = wr_ok && (addr == A_OUT)  && idx_q[sel_bit(c)];

        crb_local_copy u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .reload  (reload),
            .we_test (we_test[c]),
            .we_out  (we_out[c]),
            .wdata   (wdata),
            .test_q  (test_q[c]),
            .out_q   (out_q[c])
        );
    end

    crb_read_mux #(
        .CHIP_ID    (CHIP_ID),
        .CHIP_GRADE (CHIP_GRADE)
    ) u_rmux (
        .addr    (addr),
        .cfg_q   (cfg_q),
        .idx_q   (idx_q),
        .pwr_q   (pwr_q),
        .ref_q   (ref_q),
        .test_q  (test_q),
        .out_q   (out_q),
        .rd_byte (rd_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_byte;
        end
    end

    // R8: every read strobe yields one valid cycle, and nothing else does
    a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R7: unmapped reads return zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_mapped(addr)) |=> (rdata == 8'h00));

    // R6: globals and index are back at defaults after the reload cycle
    a_r6_globals_default: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (idx_q == D_INDEX && pwr_q == D_PWR && ref_q == D_REF && cfg_q == D_CFG));

    // R3: no local copy changes without a selecting index bit
    a_r3_none_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (idx_q & M_INDEX) == 8'h00) |=> ($stable(test_q) && $stable(out_q)));

endmodule

// File: tb/crb_bank_tb.sv
module crb_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    crb_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected rd_valid: actual %h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 idle valid: actual %b expected 0", rd_valid);
        end
        rd(8'h00, 8'h00, "R1 cfg");
        rd(8'h01, 8'h8B, "R1 id");
        rd(8'h02, 8'h20, "R1 grade");
        rd(8'h05, 8'h33, "R1 index");
        rd(8'h08, 8'h00, "R1 pwr");
        rd(8'h18, 8'h04, "R1 ref");
        rd(8'h0D, 8'h00, "R1 test");
        rd(8'h14, 8'h01, "R1 out");

        // R2 reserved index bits
        wr(8'h05, 8'hFF);
        rd(8'h05, 8'h33, "R2 reserved zero");
        wr(8'h05, 8'h20);
        rd(8'h05, 8'h20, "R2 dck only");
        wr(8'h05, 8'h33);

        // R3 broadcast and selective writes, R4 read priority
        wr(8'h0D, 8'h0A);
        wr(8'h05, 8'h01);
        wr(8'h0D, 8'h03);
        wr(8'h05, 8'h02); rd(8'h0D, 8'h0A, "R3 B broadcast kept");
        wr(8'h05, 8'h20); rd(8'h0D, 8'h0A, "R3 dck broadcast");
        wr(8'h05, 8'h10); rd(8'h0D, 8'h0A, "R3 fck broadcast");
        wr(8'h05, 8'h33); rd(8'h0D, 8'h03, "R4 A priority");
        wr(8'h05, 8'h00);
        wr(8'h0D, 8'h0F);
        rd(8'h0D, 8'h00, "R4 none selected");
        wr(8'h05, 8'h02); rd(8'h0D, 8'h0A, "R3 no copy written");
        wr(8'h05, 8'h30);
        wr(8'h14, 8'h06);
        wr(8'h05, 8'h20); rd(8'h14, 8'h06, "R3 dck out");
        wr(8'h05, 8'h03); rd(8'h14, 8'h01, "R3 A out untouched");
        wr(8'h05, 8'h10); rd(8'h14, 8'h06, "R3 fck out");
        wr(8'h05, 8'h22);
        wr(8'h0D, 8'h05);
        wr(8'h05, 8'h02); rd(8'h0D, 8'h05, "R3 B pair");
        wr(8'h05, 8'h20); rd(8'h0D, 8'h05, "R3 dck pair");
        wr(8'h05, 8'h30); rd(8'h0D, 8'h05, "R4 dck over fck");
        wr(8'h05, 8'h10); rd(8'h0D, 8'h0A, "R3 fck unselected");
        wr(8'h05, 8'h01); rd(8'h0D, 8'h03, "R3 A unselected");

        // R9 field masking
        wr(8'h0D, 8'hF7);
        rd(8'h0D, 8'h07, "R9 test mask");
        wr(8'h00, 8'hC3);
        rd(8'h00, 8'h03, "R9 cfg mask");

        // R5 globals ignore the index
        wr(8'h05, 8'h00);
        wr(8'h08, 8'hFF);
        rd(8'h08, 8'h03, "R5 pwr idx0");
        wr(8'h18, 8'h02);
        rd(8'h18, 8'h02, "R5 ref idx0");
        wr(8'h05, 8'h33);
        rd(8'h08, 8'h03, "R5 pwr idx33");

        // R7 unsupported and read-only addresses
        wr(8'h13, 8'h55);
        rd(8'h13, 8'h00, "R7 unmapped read");
        rd(8'h08, 8'h03, "R7 pwr unchanged");
        rd(8'h18, 8'h02, "R7 ref unchanged");
        wr(8'h01, 8'h00);
        rd(8'h01, 8'h8B, "R7 id read-only");
        rd(8'hFF, 8'h00, "R7 top address");

        // R6 soft reset with a write in the reload cycle
        wr(8'h05, 8'h01);
        @(negedge clk);
        addr = 8'h00; wdata = 8'h22; wr_en = 1'b1;
        @(negedge clk);
        addr = 8'h08; wdata = 8'h02;
        @(negedge clk);
        wr_en = 1'b0;
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 valid after writes: actual %b expected 0", rd_valid);
        end
        rd(8'h00, 8'h00, "R6 srst bit clear");
        rd(8'h05, 8'h33, "R6 index default");
        rd(8'h08, 8'h00, "R6 write in reload dropped");
        rd(8'h18, 8'h04, "R6 ref default");
        rd(8'h0D, 8'h00, "R6 A test default");
        wr(8'h05, 8'h20);
        rd(8'h14, 8'h01, "R6 dck out default");
        wr(8'h05, 8'h10);
        rd(8'h0D, 8'h00, "R6 fck test default");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing results: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule